// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recently used page mappings and translates a 32-bit virtual address to a 32-bit physical address in the same cycle the lookup is presented. The upper 20 bits (the page number) are compared against every stored entry at once. The lower 12 bits (the offset inside a 4 KB page) pass through untouched. Each entry also holds a frame number, a valid flag, referenced and dirty flags, and three permission bits. A lookup reports exactly one outcome: a hit, a miss, or a permission fault.

After a miss, the surrounding logic fetches the mapping elsewhere and loads it through the fill port. A fill goes to an empty slot when one exists. Otherwise a victim is chosen, either least-recently-used or pseudo-random, as selected by a parameter. A single flush input drops every mapping at once. The entry count defaults to 8 and may be raised to a few hundred.

Top module: `xlat_tlb`

## Requirements
- R1: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is high in the same cycle. While `lk_valid` is low, all three are low and `lk_paddr`, `lk_rights`, `lk_dirty` and `lk_refd` read zero.
- R2: On a hit, `lk_paddr` is the entry's frame number in bits 31:12, with `lk_vaddr[11:0]` in bits 11:0. `lk_rights` shows the entry's permission bits.
- R3: Permission bits are bit 0 read, bit 1 write and bit 2 execute. `lk_kind` is 0 for load, 1 for store, 2 for fetch; the value 3 is never permitted. A matching lookup whose kind lacks its permission bit gives `lk_fault` rather than `lk_hit`, and changes neither the dirty nor the referenced flag.
- R4: `lk_refd` and `lk_dirty` report the flags as stored before the current access. A hit sets the referenced flag from the next cycle on.
- R5: A store hit sets the entry's dirty flag from the next cycle on.
- R6: `flush_all` clears every valid flag in one cycle. A fill presented in the same cycle is discarded.
- R7: A fill is visible from the next cycle, with referenced and dirty clear. A fill whose page number is already present overwrites that entry, so no page number is ever held twice.
- R8: A fill of a new page number uses the lowest-numbered invalid slot if any slot is invalid.
- R9: With `POLICY` = least-recently-used and all slots valid, a fill replaces the entry whose last hit or fill is oldest.
- R10: With `POLICY` = random and all slots valid, a fill replaces exactly one existing entry, chosen by a free-running pseudo-random sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | Match found and access permitted |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | Match found but access kind not permitted |
| lk_paddr | output | 32 | Translated physical address (zero unless hit) |
| lk_rights | output | 3 | Permission bits of the matching entry |
| lk_dirty | output | 1 | Dirty flag of the matching entry before this access |
| lk_refd | output | 1 | Referenced flag of the matching entry before this access |
| fill_valid | input | 1 | Load a new mapping this cycle |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_pfn | input | 20 | Frame number of the new mapping |
| fill_rights | input | 3 | Permission bits of the new mapping |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Replacement can only be seen once every slot is full, and only through which old page number stops hitting. Each hit also reorders recency, so the probes themselves disturb the state under test. The stimulus flushes, fills exactly as many distinct pages as there are slots, and touches a chosen page. It then works out the recency order, including the reordering caused by its own verifying hits, before each further fill. For the random policy, a second instance receives the same stimulus. There the check is that exactly the slot count of page numbers still hits after several overflowing fills.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Access kind carried on the lookup port
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  // Replacement choice when every slot is occupied
  typedef enum logic {
    REPL_LRU    = 1'b0,
    REPL_RANDOM = 1'b1
  } repl_e;

  // Permission bit positions
  localparam int RT_READ  = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_EXEC  = 2;
  localparam int RT_W     = 3;

endpackage

// File: rtl/xlat_cam.sv
// Parallel compare of a key against every stored tag.
module xlat_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign any_o = |match_o;

  // lowest matching slot wins (only one can match in normal operation)
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
// Slot selection for a fill: empty slot first, then the configured policy.
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int    ENTRIES = 8,
  parameter repl_e POLICY  = REPL_LRU,
  localparam int   IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               touch_en_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  output logic [IDX_W-1:0]   victim_o
);

  logic             has_inv;
  logic [IDX_W-1:0] inv_idx;
  logic [IDX_W-1:0] repl_idx;

  always_comb begin
    has_inv = 1'b0;
    inv_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_inv = 1'b1;
        inv_idx = IDX_W'(i);
      end
    end
  end

  if (POLICY == REPL_LRU) begin : g_lru
    // Each slot holds its rank: 0 = most recent, ENTRIES-1 = oldest.
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [ENTRIES-1:0][IDX_W-1:0] age_d;
    logic [ENTRIES-1:0]            is_oldest;

    always_comb begin
      age_d = age_q;
      if (touch_en_i) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touch_idx_i) begin
            age_d[i] = '0;
          end else if (age_q[i] < age_q[touch_idx_i]) begin
            age_d[i] = age_q[i] + 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else begin
        age_q <= age_d;
      end
    end

    always_comb begin
      repl_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        is_oldest[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
        if (is_oldest[i]) repl_idx = IDX_W'(i);
      end
    end

    // R9
    lru_unique_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_oldest) == 1);

  end else begin : g_rnd
    localparam int LFSR_W = 16;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;
    logic              unused_touch;

    assign unused_touch = ^{touch_en_i, touch_idx_i};
    assign lfsr_d = {lfsr_q[LFSR_W-2:0],
                     lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= 16'hACE1;
      else        lfsr_q <= lfsr_d;
    end

    assign repl_idx = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));

    // R10
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
  end

  assign victim_o = has_inv ? inv_idx : repl_idx;

  // R8
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_inv |-> !valid_i[victim_o]);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int    ENTRIES = 8,
  parameter int    VPN_W   = 20,
  parameter int    PFN_W   = 20,
  parameter int    OFS_W   = 12,
  parameter repl_e POLICY  = REPL_LRU,
  localparam int   IDX_W   = $clog2(ENTRIES),
  localparam int   VA_W    = VPN_W + OFS_W,
  localparam int   PA_W    = PFN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [RT_W-1:0]  lk_rights,
  output logic             lk_dirty,
  output logic             lk_refd,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [RT_W-1:0]  fill_rights,
  input  logic             flush_all
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // entry storage
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            refd_q, refd_d;
  logic [ENTRIES-1:0]            dirty_q, dirty_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0][RT_W-1:0]  rights_q;

  // lookup side
  logic [ENTRIES-1:0] l_match;
  logic               l_any;
  logic [IDX_W-1:0]   l_idx;
  logic [VPN_W-1:0]   l_vpn;
  logic               permit;
  logic               is_store;
  logic [RT_W-1:0]    sel_rights;

  // fill side
  logic [ENTRIES-1:0] f_match;
  logic               f_any;
  logic [IDX_W-1:0]   f_idx;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   fill_slot;
  logic               fill_go;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  assign l_vpn = lk_vaddr[VA_W-1:OFS_W];

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_look_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .key_i   (l_vpn),
    .match_o (l_match),
    .any_o   (l_any),
    .idx_o   (l_idx)
  );

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .key_i   (fill_vpn),
    .match_o (f_match),
    .any_o   (f_any),
    .idx_o   (f_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .POLICY(POLICY)) u_victim (
    .clk         (clk),
    .rst_n       (rst_ok),
    .valid_i     (valid_q),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .victim_o    (victim)
  );

  // permission check
  assign sel_rights = rights_q[l_idx];
  assign is_store   = (lk_kind == ACC_STORE);

  always_comb begin
    unique case (lk_kind)
      ACC_LOAD:  permit = sel_rights[RT_READ];
      ACC_STORE: permit = sel_rights[RT_WRITE];
      ACC_FETCH: permit = sel_rights[RT_EXEC];
      default:   permit = 1'b0;
    endcase
  end

  assign lk_hit    = lk_valid && l_any && permit;
  assign lk_fault  = lk_valid && l_any && !permit;
  assign lk_miss   = lk_valid && !l_any;
  assign lk_paddr  = lk_hit ? {pfn_q[l_idx], lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_rights = (lk_valid && l_any) ? sel_rights     : '0;
  assign lk_dirty  = (lk_valid && l_any) ? dirty_q[l_idx] : 1'b0;
  assign lk_refd   = (lk_valid && l_any) ? refd_q[l_idx]  : 1'b0;

  // fill slot: overwrite an existing copy, else the chosen victim
  assign fill_go   = fill_valid && !flush_all;
  assign fill_slot = f_any ? f_idx : victim;
  assign touch_en  = fill_go || lk_hit;
  assign touch_idx = fill_go ? fill_slot : l_idx;

  // next state of the flag arrays
  always_comb begin
    valid_d = valid_q;
    refd_d  = refd_q;
    dirty_d = dirty_q;
    if (lk_hit) begin
      refd_d[l_idx] = 1'b1;
      if (is_store) dirty_d[l_idx] = 1'b1;
    end
    if (fill_go) begin
      valid_d[fill_slot] = 1'b1;
      refd_d[fill_slot]  = 1'b0;
      dirty_d[fill_slot] = 1'b0;
    end
    if (flush_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      valid_q <= '0;
      refd_q  <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      refd_q  <= refd_d;
      dirty_q <= dirty_d;
    end
  end

  // mapping payload, written only on a fill
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_slot]    <= fill_vpn;
      pfn_q[fill_slot]    <= fill_pfn;
      rights_q[fill_slot] <= fill_rights;
    end
  end

  // R1
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

  // R7
  no_dup_look_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(l_match));

  // R7
  no_dup_fill_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(f_match));

  // R7
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (fill_valid && !flush_all) |=>
      (!(lk_valid && l_vpn == $past(fill_vpn)) || !lk_miss));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_all |=> !lk_hit && !lk_fault);

  // R5
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (lk_hit && lk_kind == ACC_STORE && !fill_valid && !flush_all) |=>
      (!(lk_valid && l_vpn == $past(l_vpn)) || lk_dirty));

endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  import xlat_pkg::*;

  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic [2:0]  fill_rights;
  logic        flush_all;

  logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_refd;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_rights;
  logic        r_hit, r_miss, r_fault, r_dirty, r_refd;
  logic [31:0] r_paddr;
  logic [2:0]  r_rights;

  // captured results of the last lookup
  logic        c_hit, c_miss, c_fault, c_dirty, c_refd, c_rhit;
  logic [31:0] c_paddr;
  logic [2:0]  c_rights;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .POLICY(REPL_LRU)) u_xlat_tlb (
    .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_kind,
    .lk_hit, .lk_miss, .lk_fault, .lk_paddr, .lk_rights, .lk_dirty, .lk_refd,
    .fill_valid, .fill_vpn, .fill_pfn, .fill_rights, .flush_all
  );

  xlat_tlb #(.ENTRIES(N), .POLICY(REPL_RANDOM)) u_xlat_tlb_rnd (
    .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_kind,
    .lk_hit(r_hit), .lk_miss(r_miss), .lk_fault(r_fault), .lk_paddr(r_paddr),
    .lk_rights(r_rights), .lk_dirty(r_dirty), .lk_refd(r_refd),
    .fill_valid, .fill_vpn, .fill_pfn, .fill_rights, .flush_all
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kd);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kd;
    #1;
    c_hit = lk_hit; c_miss = lk_miss; c_fault = lk_fault;
    c_paddr = lk_paddr; c_rights = lk_rights; c_dirty = lk_dirty; c_refd = lk_refd;
    c_rhit = r_hit;
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] rt);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_rights = rt;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic flush();
    flush_all = 1'b1;
    @(posedge clk); #1;
    flush_all = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 idle hit", lk_hit, 0);
    chk("R1 idle miss", lk_miss, 0);
    chk("R1 idle paddr", lk_paddr, 0);
    look(32'h0000_1000, 2'd0);
    chk("R1 miss after reset", {c_hit, c_miss, c_fault}, 3'b010);
  endtask

  task automatic t_translate();
    fill(20'h12345, 20'hABCDE, 3'b111);
    look(32'h1234_5678, 2'd0);
    chk("R2 hit", c_hit, 1);
    chk("R2 paddr", c_paddr, 32'hABCD_E678);
    chk("R2 rights", c_rights, 3'b111);
    chk("R4 refd before first hit", c_refd, 0);
    look(32'h1234_5FFF, 2'd2);
    chk("R4 refd set by hit", c_refd, 1);
    chk("R2 paddr offset", c_paddr, 32'hABCD_EFFF);
  endtask

  task automatic t_store();
    look(32'h1234_5004, 2'd1);
    chk("R5 store hit", c_hit, 1);
    chk("R4 dirty before store", c_dirty, 0);
    look(32'h1234_5008, 2'd0);
    chk("R5 dirty after store", c_dirty, 1);
  endtask

  task automatic t_fault();
    fill(20'h00100, 20'h00222, 3'b001);
    look(32'h0010_0010, 2'd1);
    chk("R3 store on read-only faults", {c_hit, c_miss, c_fault}, 3'b001);
    chk("R3 fault paddr zero", c_paddr, 0);
    look(32'h0010_0010, 2'd2);
    chk("R3 fetch on read-only faults", c_fault, 1);
    look(32'h0010_0010, 2'd3);
    chk("R3 kind 3 faults", c_fault, 1);
    look(32'h0010_0010, 2'd0);
    chk("R3 load permitted", c_hit, 1);
    chk("R3 fault left dirty clear", c_dirty, 0);
    chk("R3 fault left refd clear", c_refd, 0);
  endtask

  task automatic t_flush();
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h77777; fill_pfn = 20'h1; fill_rights = 3'b111;
    @(posedge clk); #1;
    flush_all = 1'b0; fill_valid = 1'b0;
    look(32'h1234_5000, 2'd0);
    chk("R6 old entry gone", c_miss, 1);
    look(32'h7777_7000, 2'd0);
    chk("R6 same-cycle fill dropped", c_miss, 1);
  endtask

  task automatic t_refill();
    flush();
    fill(20'h0AAAA, 20'h00011, 3'b111);
    look(32'h0AAA_A000, 2'd1);
    fill(20'h0AAAA, 20'h00022, 3'b111);
    look(32'h0AAA_A123, 2'd0);
    chk("R7 refill new frame", c_paddr, 32'h0002_2123);
    chk("R7 refill clears dirty", c_dirty, 0);
    chk("R7 refill clears refd", c_refd, 0);
    for (int i = 1; i < N; i++) fill(20'h0B000 + 20'(i), 20'h00100 + 20'(i), 3'b111);
    look(32'h0AAA_A000, 2'd0);
    chk("R8 all slots used, first kept", c_hit, 1);
    for (int i = 1; i < N; i++) begin
      look({20'h0B000 + 20'(i), 12'h0}, 2'd0);
      chk("R8 empty slot used before eviction", c_hit, 1);
    end
  endtask

  task automatic t_lru();
    flush();
    for (int i = 0; i < N; i++) fill(20'h10000 + 20'(i), 20'h20000 + 20'(i), 3'b111);
    look(32'h1000_0000, 2'd0);                 // touch page 0
    fill(20'h10008, 20'h20008, 3'b111);        // evicts page 1
    look(32'h1000_1000, 2'd0);
    chk("R9 least recent evicted", c_miss, 1);
    look(32'h1000_8000, 2'd0);
    chk("R9 new page present", c_hit, 1);
    look(32'h1000_0000, 2'd0);
    chk("R9 recently hit page kept", c_hit, 1);
    fill(20'h10009, 20'h20009, 3'b111);        // evicts page 2
    look(32'h1000_2000, 2'd0);
    chk("R9 next oldest evicted", c_miss, 1);
    look(32'h1000_3000, 2'd0);
    chk("R9 younger page kept", c_hit, 1);
  endtask

  task automatic t_random();
    int hits;
    flush();
    for (int i = 0; i < N + 5; i++) fill(20'h30000 + 20'(i), 20'h40000 + 20'(i), 3'b111);
    hits = 0;
    for (int i = 0; i < N + 5; i++) begin
      look({20'h30000 + 20'(i), 12'h0}, 2'd0);
      if (c_rhit) hits++;
      if (i == N + 4) chk("R10 last fill present", c_rhit, 1);
    end
    chk("R10 occupancy stays full", hits, N);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_rights = '0; flush_all = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_translate();
    t_store();
    t_fault();
    t_flush();
    t_refill();
    t_lru();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule